// File: doc/BRIEF.md
# Variable Block Size Hadamard Transform

This block takes a stream of 8-bit signed pixels, grouped into 8x8 tiles that arrive in Z-order, and turns each tile into a stream of unnormalized Walsh-Hadamard coefficients in the same Z-order. Every tile also carries a block-size word that splits the tile into regions. Every 2x2 group is always transformed. A 4x4 quadrant is transformed as a whole only when its region is 4x4 or larger. The whole tile is transformed only when it is one 8x8 region. The larger transforms are never formed as matrix products. They reuse the four-point butterfly on matching coefficients of four smaller results.

Scaling is left to a later quantizer, so each level adds two bits of growth and the output is 14 bits signed. The block accepts at most one pixel per clock, with any gaps, and has no back-pressure. While the next tile is being collected, a ping-pong buffer plays the previous tile out at one coefficient per clock.

Top module: `hadamard_vbs`

## Requirements
- R1: After reset, out_valid and out_last are low and out_coef is zero. out_coef stays zero and out_last stays low on every cycle where out_valid is low.
- R2: Pixels are counted in groups of 64 from reset. Within a tile the Z index z has its quadrant in bits [5:4], its 2x2 group within the quadrant in bits [3:2], and its row-major position inside the 2x2 group in bits [1:0]. in_sizes is sampled only together with the pixel at z=0, and its value on every other pixel has no effect.
- R3: Bits [2q+1:2q] of the size word give the region code of quadrant q. Code 0 means 2x2, code 1 means 4x4, code 2 means 8x8. Code 3 is treated like code 0.
- R4: A coefficient at index z in a quadrant with code 0 or 3 equals the sum, over the four inputs z' with z'[5:2]=z[5:2], of x[z'] negated when popcount(z & z' & 3) is odd.
- R5: In a 4x4 quadrant (code 1, or code 2 in a tile that is not all code 2), coefficient z equals the sum over the sixteen inputs of that quadrant of x[z'] negated when popcount(z & z' & 15) is odd.
- R6: When all four quadrants carry code 2, coefficient z equals the sum over all 64 inputs of x[z'] negated when popcount(z & z') is odd.
- R7: In a tile where only some quadrants carry code 2, those quadrants receive the 4x4 transform only.
- R8: The coefficient for z=0 is valid on the clock after the edge that accepted the tile's last pixel. The 64 coefficients then follow on consecutive cycles in Z-order, and out_last is high only with z=63.
- R9: Input gaps of any length between pixels are tolerated. Tiles sent back to back at one pixel per clock produce an unbroken coefficient stream.
- R10: Full-range inputs never overflow the 14-bit signed output. For example, an 8x8 tile of all -128 gives a DC of -8192.
- R11: A tile of constant pixels gives non-zero coefficients only at the DC position (lowest Z index) of each selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_pix | input | 8 | Signed pixel in Z-order |
| in_sizes | input | 8 | Per-quadrant region codes, sampled with a tile's first pixel |
| out_valid | output | 1 | Coefficient present this cycle |
| out_coef | output | 14 | Signed unnormalized coefficient in Z-order |
| out_last | output | 1 | Marks the tile's final coefficient |

## Verification
The assertions watch the stream framing on every cycle. They check that the output is quiet and zero while idle, that playback starts two edges after a tile's 64th pixel, that the burst stays unbroken, and that out_last falls on the 64th coefficient. The values of the coefficients, the decoding of the region codes (including the reserved code and mixed tiles), and the fact that in_sizes is ignored after the first pixel can only be shown by the bench's scenarios. The bench sweeps every possible size word and adds constant, extreme-range and gapped tiles, and it compares each coefficient against a popcount-sign sum taken over the region.

// File: rtl/hvb_pkg.sv
package hvb_pkg;

    localparam int TILE_PIX = 64;
    localparam int GRP_PIX  = 4;
    localparam int QUADS    = 4;
    localparam int GROUPS   = TILE_PIX / GRP_PIX;
    localparam int SIZE_W   = 2 * QUADS;

    typedef enum logic [1:0] {
        SZ_2X2  = 2'd0,
        SZ_4X4  = 2'd1,
        SZ_8X8  = 2'd2,
        SZ_RSVD = 2'd3
    } blk_size_e;

    // Decoded region selection for one tile.
    typedef struct packed {
        logic       sel8;
        logic [3:0] sel4;
    } tile_cfg_t;

    // Z-order position inside a tile.
    typedef struct packed {
        logic [1:0] quad;
        logic [1:0] grp;
        logic [1:0] pos;
    } zidx_t;

    // Sign of the four-point kernel entry (row r, column c): negative when popcount(r&c) is odd.
    function automatic logic wht_neg(input logic [1:0] r, input logic [1:0] c);
        return ^(r & c);
    endfunction

    function automatic tile_cfg_t decode_sizes(input logic [SIZE_W-1:0] sizes);
        tile_cfg_t cfg;
        blk_size_e code;
        logic      all8;
        all8 = 1'b1;
        cfg  = '0;
        for (int q = 0; q < QUADS; q++) begin
            code        = blk_size_e'(sizes[2*q +: 2]);
            cfg.sel4[q] = (code == SZ_4X4) || (code == SZ_8X8);
            all8        = all8 & (code == SZ_8X8);
        end
        cfg.sel8 = all8;
        return cfg;
    endfunction

endpackage

// File: rtl/hvb_h1_stage.sv
module hvb_h1_stage
    import hvb_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int L1_W  = PIX_W + 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [PIX_W-1:0]              in_pix,
    input  logic [SIZE_W-1:0]             in_sizes,
    output logic                          wr_en,
    output logic                          wr_bank,
    output logic [3:0]                    wr_grp,
    output logic [GRP_PIX-1:0][L1_W-1:0]  wr_coef,
    output logic                          tile_done,
    output tile_cfg_t                     tile_cfg
);

    logic [5:0]              pix_cnt;
    zidx_t                   idx;
    logic                    bank;
    tile_cfg_t               cfg_q;
    logic [2:0][PIX_W-1:0]   hold;
    logic signed [L1_W-1:0]  xs [GRP_PIX];
    logic signed [L1_W-1:0]  acc;

    assign idx = zidx_t'(pix_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_cnt <= '0;
            bank    <= 1'b0;
            cfg_q   <= '0;
            hold    <= '0;
        end else if (in_valid) begin
            pix_cnt <= pix_cnt + 6'd1;
            case (idx.pos)
                2'd0:    hold[0] <= in_pix;
                2'd1:    hold[1] <= in_pix;
                2'd2:    hold[2] <= in_pix;
                default: ;
            endcase
            if (pix_cnt == 6'd0) begin
                cfg_q <= decode_sizes(in_sizes);
            end
            if (pix_cnt == 6'(TILE_PIX - 1)) begin
                bank <= ~bank;
            end
        end
    end

    // Four-point butterfly over the 2x2 group, fed by three held pixels and the live one.
    always_comb begin
        xs[0] = L1_W'($signed(hold[0]));
        xs[1] = L1_W'($signed(hold[1]));
        xs[2] = L1_W'($signed(hold[2]));
        xs[3] = L1_W'($signed(in_pix));
        acc   = '0;
        for (int k = 0; k < GRP_PIX; k++) begin
            acc = '0;
            for (int i = 0; i < GRP_PIX; i++) begin
                if (wht_neg(2'(k), 2'(i))) acc = acc - xs[i];
                else                       acc = acc + xs[i];
            end
            wr_coef[k] = acc;
        end
    end

    assign wr_en     = in_valid && (idx.pos == 2'd3);
    assign wr_bank   = bank;
    assign wr_grp    = {idx.quad, idx.grp};
    assign tile_done = in_valid && (pix_cnt == 6'(TILE_PIX - 1));
    assign tile_cfg  = cfg_q;

endmodule

// File: rtl/hvb_tile_store.sv
module hvb_tile_store
    import hvb_pkg::*;
#(
    parameter  int L1_W  = 10,
    localparam int BANKS = 2
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [3:0]                    wr_grp,
    input  logic [GRP_PIX-1:0][L1_W-1:0]  wr_coef,
    input  logic                          rd_bank,
    input  logic [1:0]                    rd_pos,
    output logic [GROUPS-1:0][L1_W-1:0]   rd_vals
);

    logic [GRP_PIX-1:0][L1_W-1:0] mem [BANKS][GROUPS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_bank][wr_grp] <= wr_coef;
        end
    end

    // Same coefficient slot of all sixteen 2x2 results, read in parallel.
    for (genvar g = 0; g < GROUPS; g++) begin : g_rd
        assign rd_vals[g] = mem[rd_bank][g][rd_pos];
    end

endmodule

// File: rtl/hvb_combine.sv
module hvb_combine
    import hvb_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int L1_W  = PIX_W + 2,
    localparam int L2_W  = PIX_W + 4,
    localparam int OUT_W = PIX_W + 6
) (
    input  logic [GROUPS-1:0][L1_W-1:0] vals,
    input  tile_cfg_t                   cfg,
    input  logic [1:0]                  quad,
    input  logic [1:0]                  grp,
    output logic signed [OUT_W-1:0]     coef
);

    logic signed [L2_W-1:0]  lvl2 [QUADS];
    logic signed [L2_W-1:0]  acc4;
    logic signed [OUT_W-1:0] acc8;

    always_comb begin
        acc4 = '0;
        for (int q = 0; q < QUADS; q++) begin
            acc4 = '0;
            for (int j = 0; j < GRP_PIX; j++) begin
                if (wht_neg(grp, 2'(j))) acc4 = acc4 - L2_W'($signed(vals[q*GRP_PIX + j]));
                else                     acc4 = acc4 + L2_W'($signed(vals[q*GRP_PIX + j]));
            end
            lvl2[q] = cfg.sel4[q] ? acc4 : L2_W'($signed(vals[q*GRP_PIX + int'(grp)]));
        end
        acc8 = '0;
        for (int q = 0; q < QUADS; q++) begin
            if (wht_neg(quad, 2'(q))) acc8 = acc8 - OUT_W'(lvl2[q]);
            else                      acc8 = acc8 + OUT_W'(lvl2[q]);
        end
        coef = cfg.sel8 ? acc8 : OUT_W'(lvl2[quad]);
    end

endmodule

// File: rtl/hadamard_vbs.sv
module hadamard_vbs
    import hvb_pkg::*;
#(
    parameter  int PIX_W = 8,
    localparam int L1_W  = PIX_W + 2,
    localparam int OUT_W = PIX_W + 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [SIZE_W-1:0] in_sizes,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_coef,
    output logic              out_last
);

    logic                         wr_en;
    logic                         wr_bank;
    logic [3:0]                   wr_grp;
    logic [GRP_PIX-1:0][L1_W-1:0] wr_coef;
    logic                         tile_done;
    tile_cfg_t                    tile_cfg;

    logic                         rd_active;
    logic                         rd_bank;
    logic [5:0]                   rd_cnt;
    tile_cfg_t                    rd_cfg;
    zidx_t                        ridx;
    logic [GROUPS-1:0][L1_W-1:0]  rd_vals;
    logic signed [OUT_W-1:0]      coef_next;

    assign ridx = zidx_t'(rd_cnt);

    hvb_h1_stage #(.PIX_W(PIX_W)) u_h1 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_sizes  (in_sizes),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_grp    (wr_grp),
        .wr_coef   (wr_coef),
        .tile_done (tile_done),
        .tile_cfg  (tile_cfg)
    );

    hvb_tile_store #(.L1_W(L1_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_grp  (wr_grp),
        .wr_coef (wr_coef),
        .rd_bank (rd_bank),
        .rd_pos  (ridx.pos),
        .rd_vals (rd_vals)
    );

    hvb_combine #(.PIX_W(PIX_W)) u_comb (
        .vals (rd_vals),
        .cfg  (rd_cfg),
        .quad (ridx.quad),
        .grp  (ridx.grp),
        .coef (coef_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            rd_bank   <= 1'b0;
            rd_cnt    <= '0;
            rd_cfg    <= '0;
            out_valid <= 1'b0;
            out_coef  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= rd_active;
            out_coef  <= rd_active ? coef_next : '0;
            out_last  <= rd_active && (rd_cnt == 6'(TILE_PIX - 1));
            if (tile_done) begin
                rd_active <= 1'b1;
                rd_bank   <= wr_bank;
                rd_cnt    <= '0;
                rd_cfg    <= tile_cfg;
            end else if (rd_active) begin
                rd_cnt <= rd_cnt + 6'd1;
                if (rd_cnt == 6'(TILE_PIX - 1)) begin
                    rd_active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/hvb_checker.sv
module hvb_checker #(
    parameter int OUT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_coef,
    input logic             out_last
);

    logic [5:0] in_cnt;
    logic [5:0] out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid)  in_cnt  <= in_cnt + 6'd1;
            if (out_valid) out_cnt <= out_cnt + 6'd1;
        end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_coef == '0 && !out_last));

    p_first_out_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cnt == 6'd63) |-> ##2 (out_valid && out_cnt == 6'd0));

    p_last_pos_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_cnt == 6'd63)));

    p_burst_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

endmodule

bind hadamard_vbs hvb_checker #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_coef  (out_coef),
    .out_last  (out_last)
);

// File: tb/hadamard_vbs_bench.sv
`timescale 1ns/1ps
module hadamard_vbs_bench;

    localparam int PIX_W = 8;
    localparam int OUT_W = 14;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [PIX_W-1:0] in_pix;
    logic [7:0]       in_sizes;
    logic             out_valid;
    logic [OUT_W-1:0] out_coef;
    logic             out_last;

    always #2 clk = ~clk;

    hadamard_vbs u_hadamard_vbs (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_sizes  (in_sizes),
        .out_valid (out_valid),
        .out_coef  (out_coef),
        .out_last  (out_last)
    );

    int          n_checks = 0;
    int          n_err    = 0;
    int          cyc      = 0;
    int          tiles_in = 0;
    int          tiles_out = 0;
    int          out_pos  = 0;
    bit          monitor_on = 0;
    int unsigned seed = 32'h1234_5678;
    int          tile_px  [64];
    int          exp_val  [4][64];
    string       exp_tag  [4][64];
    int          done_cyc [4];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (time %0t)", tag, act, expv, $time);
        end
    endtask

    // Expected coefficients from the region popcount-sign sums.
    task automatic prep_expected(input int slot, input logic [7:0] sizes, input int kind);
        bit all8;
        int code;
        int mask;
        int sum;
        bit any8;
        all8 = 1;
        any8 = 0;
        for (int q = 0; q < 4; q++) begin
            if (sizes[2*q +: 2] != 2'd2) all8 = 0;
            else any8 = 1;
        end
        for (int z = 0; z < 64; z++) begin
            code = int'(sizes[2*(z>>4) +: 2]);
            if (all8)                        mask = 63;
            else if (code == 1 || code == 2) mask = 15;
            else                             mask = 3;
            sum = 0;
            for (int z2 = 0; z2 < 64; z2++) begin
                if ((z2 & ~mask) == (z & ~mask)) begin
                    if ($countones(z & z2 & mask) % 2 == 1) sum = sum - tile_px[z2];
                    else                                    sum = sum + tile_px[z2];
                end
            end
            exp_val[slot][z] = sum;
            case (kind)
                1: exp_tag[slot][z] = "R11 constant tile";
                2: exp_tag[slot][z] = "R10 full range";
                3: exp_tag[slot][z] = "R9 gapped input";
                4: exp_tag[slot][z] = "R2 sizes only on first pixel";
                default: begin
                    if (mask == 63)               exp_tag[slot][z] = "R6 8x8 region";
                    else if (mask == 15 && any8)  exp_tag[slot][z] = "R7 mixed tile";
                    else if (mask == 15)          exp_tag[slot][z] = "R5 4x4 region";
                    else if (code == 3)           exp_tag[slot][z] = "R3 reserved code";
                    else                          exp_tag[slot][z] = "R4 2x2 group";
                end
            endcase
        end
    endtask

    task automatic send_tile(input logic [7:0] sizes, input int kind, input bit gap);
        int slot;
        slot = tiles_in % 4;
        prep_expected(slot, sizes, kind);
        for (int z = 0; z < 64; z++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = 8'(tile_px[z]);
            if (z == 0)         in_sizes = sizes;
            else if (kind == 4) in_sizes = 8'h00;
            else                in_sizes = 8'(z * 37 + 5);
            if (z == 63) done_cyc[slot] = cyc;
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_pix   = 8'h5A;
                in_sizes = 8'hFF;
            end
        end
        tiles_in++;
    endtask

    task automatic fill_random();
        for (int z = 0; z < 64; z++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            tile_px[z] = int'($signed(seed[23:16]));
        end
    endtask

    task automatic fill_const(input int v);
        for (int z = 0; z < 64; z++) tile_px[z] = v;
    endtask

    // Output monitor: value, framing and latency of every coefficient.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                check($signed(out_coef) == exp_val[tiles_out % 4][out_pos],
                      exp_tag[tiles_out % 4][out_pos],
                      int'($signed(out_coef)), exp_val[tiles_out % 4][out_pos]);
                check(out_last == (out_pos == 63), "R8 out_last position",
                      int'(out_last), int'(out_pos == 63));
                if (out_pos == 0) begin
                    check(cyc == done_cyc[tiles_out % 4] + 2, "R8 first coefficient latency",
                          cyc, done_cyc[tiles_out % 4] + 2);
                end
                if (out_pos == 63) begin
                    out_pos = 0;
                    tiles_out++;
                end else begin
                    out_pos++;
                end
            end else begin
                check(out_coef == '0 && !out_last, "R1 idle output zero",
                      int'(out_coef), 0);
                check(out_pos == 0, "R9 unbroken burst", out_pos, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_pix   = '0;
        in_sizes = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        check(out_last == 1'b0,  "R1 reset out_last",  int'(out_last), 0);
        check(out_coef == '0,    "R1 reset out_coef",  int'(out_coef), 0);
        monitor_on = 1;

        // Constant tiles: DC-only per selected region.
        fill_const(37);  send_tile(8'h00, 1, 0);
        fill_const(37);  send_tile(8'h55, 1, 0);
        fill_const(-21); send_tile(8'hAA, 1, 0);
        fill_const(90);  send_tile(8'hC6, 1, 0);

        // Extreme values.
        fill_const(127);  send_tile(8'hAA, 2, 0);
        fill_const(-128); send_tile(8'hAA, 2, 0);
        for (int z = 0; z < 64; z++) tile_px[z] = ($countones(z) % 2 == 1) ? -128 : 127;
        send_tile(8'hAA, 2, 0);
        send_tile(8'h55, 2, 0);

        // First-pixel sampling of the size word.
        fill_random(); send_tile(8'hAA, 4, 0);
        fill_random(); send_tile(8'h55, 4, 0);

        // Every size word, back to back.
        for (int s = 0; s < 256; s++) begin
            fill_random();
            send_tile(8'(s), 0, 0);
        end

        // Gapped input.
        fill_random(); send_tile(8'hAA, 3, 1);
        fill_random(); send_tile(8'h1B, 3, 1);
        fill_random(); send_tile(8'h00, 3, 1);

        @(negedge clk);
        in_valid = 1'b0;
        while (tiles_out != tiles_in) @(negedge clk);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R8 stream ends after 64 coefficients", int'(out_valid), 0);
        check(tiles_out == tiles_in, "R8 tile count", tiles_out, tiles_in);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule